// File: doc/BRIEF.md
# Message Buffer Validity Register

This block keeps one validity flag for each of the sixteen message buffers of a CAN-style controller. The transmit and receive engines read the flags as a vector, and a buffer whose flag is low takes no part in either direction. Software reads and writes the flags one byte at a time over a small synchronous bus.

Setting a flag takes effect at once. Clearing a flag depends on what the buffer is doing. While the buffer is receiving a frame, or is idle, the clear applies at the next clock edge. While the buffer is transmitting, or while a received message is being written into it, the clear is held in a per-buffer pending bit. The flag stays high until the transmission ends or the store completes, and then drops. A flag with a pending clear still reads as 1, so software can poll until the clear has taken effect.

Top module: `msgbuf_valid_reg`

## Requirements
- R1: After a synchronous reset, every flag is 0, `buf_valid` is 0 and `bus_rdata` is 0.
- R2: Address 0 maps buffers 0 to 7 and address 1 maps buffers 8 to 15. Bit i of the byte belongs to buffer (8 × address + i). `bus_rdata` shows the addressed byte as it stood at the previous rising edge, so a read has one cycle of latency.
- R3: Writing a 1 to a bit sets that buffer's flag, visible on `buf_valid` one cycle later. The same write cancels any pending clear for that buffer, so a later end-of-activity event leaves the flag set.
- R4: Writing a 0 to a valid buffer that is neither transmitting nor storing drops its flag one cycle later. This applies even while `rx_busy` is high for that buffer.
- R5: Writing a 0 to a valid buffer whose `tx_busy` is high keeps the flag at 1 until a cycle with `tx_done` high. The flag reads 0 one cycle after that event.
- R6: Writing a 0 to a valid buffer whose `store_busy` is high keeps the flag at 1 until `store_done`, then drops it one cycle later. Storing takes priority over `rx_busy`.
- R7: If `tx_done` or `store_done` arrives in the same cycle as a clearing write, the flag drops one cycle later, with no deferral.
- R8: A buffer with a pending clear reads as 1 on both `bus_rdata` and `buf_valid`.
- R9: Writing a 0 to a buffer that is already invalid, or a 1 to a buffer that is valid with nothing pending, leaves it unchanged.
- R10: A pending clear also takes effect one cycle after the deferring activity ends (both `tx_busy` and `store_busy` low), even if no end event was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Byte select: 0 for the lower buffers, 1 for the upper buffers |
| bus_we | input | 1 | Byte write enable |
| bus_wdata | input | 8 | Write data, one bit per buffer |
| bus_rdata | output | 8 | Registered read data for the addressed byte |
| tx_busy | input | 16 | Buffer is transmitting |
| tx_done | input | 16 | Transmission ended, successfully or with an error |
| rx_busy | input | 16 | Buffer is taking part in a reception |
| store_busy | input | 16 | Received message is being written into the buffer |
| store_done | input | 16 | Write of the received message has finished |
| buf_valid | output | 16 | Effective validity vector for the engines |

## Verification
Clears are tried against four activity patterns: idle, reception only, transmission, and storing with reception also active. The outcomes separate a flag that drops at once from one that must wait. End events are placed in three positions: several cycles after a clearing write, in the same cycle as the write, and never (the activity simply stops). These show whether the pending bit and the same-cycle rule are kept apart. A set issued while a clear is pending shows the cancel, and whole-byte writes that mix ones and zeros show lane and bit mapping and the no-effect cases. A long stretch of random activity and writes follows, and the register is compared every cycle with a behavioural model.

// File: rtl/msgvalid_pkg.sv
package msgvalid_pkg;

    localparam int NUM_BUF_DEF = 16;
    localparam int BYTE_W_DEF  = 8;

    // Activity class, highest deferral priority last.
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_RX    = 2'd1,
        ACT_STORE = 2'd2,
        ACT_TX    = 2'd3
    } act_e;

    typedef struct packed {
        logic tx_busy;
        logic tx_done;
        logic rx_busy;
        logic st_busy;
        logic st_done;
    } buf_stat_t;

    function automatic act_e classify(input buf_stat_t s);
        if (s.tx_busy)      return ACT_TX;
        else if (s.st_busy) return ACT_STORE;
        else if (s.rx_busy) return ACT_RX;
        else                return ACT_IDLE;
    endfunction

    function automatic logic defers(input act_e a);
        return (a == ACT_TX) || (a == ACT_STORE);
    endfunction

endpackage

// File: rtl/mbv_bus_port.sv
module mbv_bus_port
    import msgvalid_pkg::*;
#(
    parameter int NUM_BUF = NUM_BUF_DEF,
    parameter int BYTE_W  = BYTE_W_DEF,
    parameter int ADDR_W  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               we,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [NUM_BUF-1:0] flags,
    output logic [NUM_BUF-1:0] wr_set,
    output logic [NUM_BUF-1:0] wr_clr,
    output logic [BYTE_W-1:0]  rdata
);
    localparam int NUM_LANES = NUM_BUF / BYTE_W;

    logic [BYTE_W-1:0] rd_sel;

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        logic hit;
        assign hit = we && (addr == ADDR_W'(ln));
        assign wr_set[ln*BYTE_W +: BYTE_W] = hit ? wdata  : '0;
        assign wr_clr[ln*BYTE_W +: BYTE_W] = hit ? ~wdata : '0;
    end

    always_comb begin
        rd_sel = '0;
        for (int ln = 0; ln < NUM_LANES; ln++) begin
            if (addr == ADDR_W'(ln))
                rd_sel = flags[ln*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_sel;
    end

endmodule

// File: rtl/mbv_flag_cell.sv
module mbv_flag_cell
    import msgvalid_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  buf_stat_t stat,
    input  logic      wr_set,
    input  logic      wr_clr,
    output logic      valid
);
    logic pend;
    act_e act;
    logic clear_req;
    logic fire;

    assign act       = classify(stat);
    assign clear_req = pend || (wr_clr && valid);
    assign fire      = clear_req && (stat.tx_done || stat.st_done || !defers(act));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            pend  <= 1'b0;
        end else if (wr_set) begin
            valid <= 1'b1;
            pend  <= 1'b0;
        end else if (fire) begin
            valid <= 1'b0;
            pend  <= 1'b0;
        end else if (clear_req) begin
            pend  <= 1'b1;
        end
    end

    assert_pend_valid_R8: assert property (@(posedge clk) disable iff (rst)
        pend |-> valid);

    assert_set_R3: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> (valid && !pend));

    assert_tx_defer_R5: assert property (@(posedge clk) disable iff (rst)
        (valid && wr_clr && !wr_set && stat.tx_busy && !stat.tx_done && !stat.st_done) |=> valid);

    assert_quiet_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (valid && wr_clr && !wr_set && !stat.tx_busy && !stat.st_busy) |=> !valid);

    assert_event_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && wr_clr && !wr_set && (stat.tx_done || stat.st_done)) |=> !valid);

    assert_no_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (!valid && !wr_set) |=> !valid);

endmodule

// File: rtl/msgbuf_valid_reg.sv
module msgbuf_valid_reg
    import msgvalid_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [0:0]  bus_addr,
    input  logic        bus_we,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [15:0] tx_busy,
    input  logic [15:0] tx_done,
    input  logic [15:0] rx_busy,
    input  logic [15:0] store_busy,
    input  logic [15:0] store_done,
    output logic [15:0] buf_valid
);
    localparam int NUM_BUF = NUM_BUF_DEF;
    localparam int BYTE_W  = BYTE_W_DEF;

    logic [NUM_BUF-1:0] wr_set;
    logic [NUM_BUF-1:0] wr_clr;
    logic [NUM_BUF-1:0] flags;

    mbv_bus_port #(
        .NUM_BUF (NUM_BUF),
        .BYTE_W  (BYTE_W),
        .ADDR_W  (1)
    ) bus_i (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .flags  (flags),
        .wr_set (wr_set),
        .wr_clr (wr_clr),
        .rdata  (bus_rdata)
    );

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        buf_stat_t st;
        assign st = '{tx_busy: tx_busy[b], tx_done: tx_done[b], rx_busy: rx_busy[b],
                      st_busy: store_busy[b], st_done: store_done[b]};
        mbv_flag_cell cell_i (
            .clk    (clk),
            .rst    (rst),
            .stat   (st),
            .wr_set (wr_set[b]),
            .wr_clr (wr_clr[b]),
            .valid  (flags[b])
        );
    end

    assign buf_valid = flags;

endmodule

// File: tb/msgbuf_valid_reg_tb_top.sv
`timescale 1ns/100ps
module msgbuf_valid_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [0:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] tx_busy = '0, tx_done = '0, rx_busy = '0;
    logic [15:0] store_busy = '0, store_done = '0;
    logic [15:0] buf_valid;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    msgbuf_valid_reg dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_busy(tx_busy),
        .tx_done(tx_done), .rx_busy(rx_busy), .store_busy(store_busy),
        .store_done(store_done), .buf_valid(buf_valid)
    );

    // Behavioural reference, updated at each rising edge.
    logic [15:0] m_valid, m_pend;
    logic [7:0]  m_rdata;
    logic        lane_hit, bit_one, wants, busy_hold, ended;

    always @(posedge clk) begin
        if (rst) begin
            m_valid = '0; m_pend = '0; m_rdata = '0;
        end else begin
            m_rdata = bus_addr[0] ? m_valid[15:8] : m_valid[7:0];
            for (int b = 0; b < 16; b++) begin
                lane_hit  = bus_we && ((b / 8) == int'(bus_addr[0]));
                bit_one   = bus_wdata[b % 8];
                wants     = m_pend[b] || (lane_hit && !bit_one && m_valid[b]);
                busy_hold = tx_busy[b] || store_busy[b];
                ended     = tx_done[b] || store_done[b];
                if (lane_hit && bit_one) begin
                    m_valid[b] = 1'b1; m_pend[b] = 1'b0;
                end else if (wants && (ended || !busy_hold)) begin
                    m_valid[b] = 1'b0; m_pend[b] = 1'b0;
                end else if (wants) begin
                    m_pend[b] = 1'b1;
                end
            end
        end
        #1;
        n_chk++;
        if (buf_valid !== m_valid) begin
            n_fail++;
            $display("FAIL %s buf_valid actual=%h expected=%h at %0t", cur_req, buf_valid, m_valid, $time);
        end
        n_chk++;
        if (bus_rdata !== m_rdata) begin
            n_fail++;
            $display("FAIL R2/%s bus_rdata actual=%h expected=%h at %0t", cur_req, bus_rdata, m_rdata, $time);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        idle(4);
        rst = 1'b0;
        idle(2);
        // R2 R3: fill both lanes, read each.
        cur_req = "R3";
        wr(1'b0, 8'hFF);
        wr(1'b1, 8'hA5);
        cur_req = "R2";
        bus_addr = 1'b1; idle(2);
        wr(1'b1, 8'hFF);
        bus_addr = 1'b0; idle(2);
        // R4: idle clear of buffer 0, rx-only clear of buffer 1.
        cur_req = "R4";
        wr(1'b0, 8'hFE);
        rx_busy[1] = 1'b1;
        wr(1'b0, 8'hFC);
        idle(2); rx_busy[1] = 1'b0;
        // R8 then R5: deferred clear during transmission of buffer 2.
        tx_busy[2] = 1'b1;
        cur_req = "R8";
        wr(1'b0, 8'hF8);
        idle(4);
        cur_req = "R5";
        tx_done[2] = 1'b1; idle(1);
        tx_done[2] = 1'b0; tx_busy[2] = 1'b0; idle(2);
        // R6: store with reception active on buffer 3.
        cur_req = "R6";
        store_busy[3] = 1'b1; rx_busy[3] = 1'b1;
        wr(1'b0, 8'hF0);
        idle(3);
        store_done[3] = 1'b1; idle(1);
        store_done[3] = 1'b0; store_busy[3] = 1'b0; rx_busy[3] = 1'b0; idle(2);
        // R7: end event in the clearing cycle for buffer 4.
        cur_req = "R7";
        tx_busy[4] = 1'b1;
        @(negedge clk);
        tx_done[4] = 1'b1; bus_addr = 1'b0; bus_we = 1'b1; bus_wdata = 8'hE0;
        @(negedge clk);
        bus_we = 1'b0; tx_done[4] = 1'b0; tx_busy[4] = 1'b0;
        idle(2);
        // R3: set cancels a pending clear on buffer 5.
        cur_req = "R3";
        tx_busy[5] = 1'b1;
        wr(1'b0, 8'hC0);
        idle(2);
        wr(1'b0, 8'hE0);
        tx_done[5] = 1'b1; idle(1);
        tx_done[5] = 1'b0; tx_busy[5] = 1'b0; idle(2);
        // R9: writes that change nothing.
        cur_req = "R9";
        wr(1'b0, 8'hE0);
        wr(1'b1, 8'hFF);
        idle(2);
        // R10: activity on buffer 6 stops without an end event.
        cur_req = "R10";
        tx_busy[6] = 1'b1;
        wr(1'b0, 8'hA0);
        idle(3);
        tx_busy[6] = 1'b0; idle(3);
        // Mixed random traffic.
        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            tx_busy    = 16'($urandom) & 16'($urandom);
            store_busy = 16'($urandom) & 16'($urandom) & 16'($urandom);
            rx_busy    = 16'($urandom);
            tx_done    = tx_busy & 16'($urandom) & 16'($urandom);
            store_done = store_busy & 16'($urandom) & 16'($urandom);
            bus_addr   = 1'($urandom);
            bus_we     = ($urandom % 4) == 0;
            bus_wdata  = 8'($urandom);
        end
        @(negedge clk);
        bus_we = 1'b0; tx_busy = '0; store_busy = '0; rx_busy = '0; tx_done = '0; store_done = '0;
        idle(3);
        // R1: reset again after activity.
        cur_req = "R1";
        rst = 1'b1; idle(3);
        rst = 1'b0; idle(2);
        finish_run();
    end

endmodule